// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects level-held interrupt lines from a set of devices and hands them to a small group of CPU cores. Software sets four things through a write-only configuration port: a priority for each source, an enable for each source, the core each source goes to, and a priority threshold for each core. The controller captures a rising edge on a line as a pending request. It then decides, for each core, which eligible request should be served first. The request output of a core is raised whenever that core has something to serve.

A core takes work in two steps. First it pulses its claim strobe. In that same cycle it reads the identifier of the winning source, and the controller moves that source from pending to in service. When the handler is done, the core writes the same identifier back as an end of interrupt. Until that write arrives, the source cannot be delivered again. Identifier 0 never names a source. A claim returns 0 when nothing is eligible, for example when a line was raised and then dropped again before the core reached it.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every core request output is low, every claim identifier reads 0, and all priorities, enables, targets and thresholds are 0.
- R2: A pending source is delivered to a core only if its priority is strictly greater than that core's threshold, so priority 0 is never delivered.
- R3: A source whose enable bit is 0 is not delivered, but it keeps its pending state and is delivered once it is enabled again.
- R4: A source is delivered only to the core named in its target field. Two cores never see the same nonzero identifier at once.
- R5: Among the eligible sources of a core, the one with the highest priority wins. When priorities are equal, the lowest identifier wins. Line k has identifier k+1.
- R6: A claim returns the winner's identifier in the strobe cycle, clears its pending bit and marks it in service. An in-service source is not delivered again, even after a new rising edge on its line.
- R7: An end-of-interrupt write with a nonzero identifier clears that source's in-service mark. A rising edge captured while the source was in service is then delivered, as long as the line is still held high.
- R8: A pending request is dropped when its line falls before the claim. A claim with nothing eligible returns 0 and changes no state.
- R9: Only a rising edge makes a source pending. A line that stays high through claim and end of interrupt is not delivered again.
- R10: A core's request output is registered. It follows a change in pending state or configuration one clock later, while the claim identifier follows in the same cycle.

Configuration select codes on `cfg_sel`: 0 = priority (`cfg_idx` = line, all data bits), 1 = enable (`cfg_idx` = line, data bit 0), 2 = target (`cfg_idx` = line, low data bits), 3 = threshold (`cfg_idx` = core; writes to a core index that does not exist are ignored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_line | input | NUM_SRC | Device interrupt lines, synchronous to clk |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register kind select |
| cfg_idx | input | IDX_W | Line or core index |
| cfg_wdata | input | PRIO_W | Write data |
| irq | output | NUM_CORE | Per-core interrupt request |
| claim_req | input | NUM_CORE | Per-core claim strobe |
| claim_id | output | NUM_CORE*ID_W | Per-core winning identifier, 0 = none |
| eoi_req | input | NUM_CORE | Per-core end-of-interrupt strobe |
| eoi_id | input | NUM_CORE*ID_W | Identifier being completed |

## Verification
The bench uses the default build: 8 lines, 2 cores and 3-bit priorities. With these values, three lines can share one priority, so the lowest-identifier tie rule is exercised. The priority range holds both a zero value and thresholds that sit exactly at a source's priority. Two cores are enough to show that routing sends a source to one core while the other core claims nothing.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [1:0] {
    SEL_PRIO = 2'd0,
    SEL_EN   = 2'd1,
    SEL_TGT  = 2'd2,
    SEL_THR  = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int NUM_CORE = 2,
  parameter int PRIO_W   = 3,
  parameter int CORE_W   = 1,
  parameter int IDX_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_sel,
  input  logic [IDX_W-1:0]           cfg_idx,
  input  logic [PRIO_W-1:0]          cfg_wdata,
  output logic [NUM_SRC*PRIO_W-1:0]  prio_flat,
  output logic [NUM_SRC-1:0]         src_en,
  output logic [NUM_SRC*CORE_W-1:0]  tgt_flat,
  output logic [NUM_CORE*PRIO_W-1:0] thr_flat
);

  logic [NUM_SRC*PRIO_W-1:0]  prio_q, prio_d;
  logic [NUM_SRC-1:0]         en_q, en_d;
  logic [NUM_SRC*CORE_W-1:0]  tgt_q, tgt_d;
  logic [NUM_CORE*PRIO_W-1:0] thr_q, thr_d;
  cfg_sel_e                   sel;

  assign sel = cfg_sel_e'(cfg_sel);

  always_comb begin
    prio_d = prio_q;
    en_d   = en_q;
    tgt_d  = tgt_q;
    thr_d  = thr_q;
    if (cfg_we) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (int'(cfg_idx) == s) begin
          if (sel == SEL_PRIO) prio_d[s*PRIO_W +: PRIO_W] = cfg_wdata;
          if (sel == SEL_EN)   en_d[s] = cfg_wdata[0];
          if (sel == SEL_TGT)  tgt_d[s*CORE_W +: CORE_W] = cfg_wdata[CORE_W-1:0];
        end
      end
      for (int c = 0; c < NUM_CORE; c++) begin
        if (int'(cfg_idx) == c && sel == SEL_THR)
          thr_d[c*PRIO_W +: PRIO_W] = cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      tgt_q  <= '0;
      thr_q  <= '0;
    end else if (cfg_we) begin
      prio_q <= prio_d;
      en_q   <= en_d;
      tgt_q  <= tgt_d;
      thr_q  <= thr_d;
    end
  end

  assign prio_flat = prio_q;
  assign src_en    = en_q;
  assign tgt_flat  = tgt_q;
  assign thr_flat  = thr_q;

endmodule

// File: rtl/pic_src_gate.sv
module pic_src_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic claim_hit,
  input  logic eoi_hit,
  output logic pend,
  output logic ins
);

  logic line_q, pend_q, ins_q;
  logic pend_d, ins_d, rise;

  assign rise = line && !line_q;

  always_comb begin
    pend_d = pend_q;
    if (claim_hit)  pend_d = 1'b0;
    else if (rise)  pend_d = 1'b1;
    else if (!line) pend_d = 1'b0;
    ins_d = ins_q;
    if (claim_hit)    ins_d = 1'b1;
    else if (eoi_hit) ins_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      pend_q <= 1'b0;
      ins_q  <= 1'b0;
    end else begin
      line_q <= line;
      pend_q <= pend_d;
      ins_q  <= ins_d;
    end
  end

  assign pend = pend_q;
  assign ins  = ins_q;

  // R6
  claim_moves_to_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim_hit |=> (ins_q && !pend_q));

  // R7
  eoi_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !claim_hit) |=> !ins_q);

  // R8
  retract_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!line && !rise) |=> !pend_q);

endmodule

// File: rtl/pic_core_arb.sv
module pic_core_arb #(
  parameter int NUM_SRC  = 8,
  parameter int PRIO_W   = 3,
  parameter int CORE_W   = 1,
  parameter int ID_W     = 4,
  parameter int CORE_IDX = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC-1:0]        ins,
  input  logic [NUM_SRC-1:0]        src_en,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  logic [NUM_SRC*CORE_W-1:0] tgt_flat,
  input  logic [PRIO_W-1:0]         thr,
  output logic [ID_W-1:0]           win_id
);

  logic [NUM_SRC-1:0] elig;
  logic [PRIO_W-1:0]  best_prio;
  logic [ID_W-1:0]    best_id;
  logic               outranked;

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      elig[s] = pend[s] && !ins[s] && src_en[s]
                && (tgt_flat[s*CORE_W +: CORE_W] == CORE_W'(CORE_IDX))
                && (prio_flat[s*PRIO_W +: PRIO_W] > thr);
    end
  end

  always_comb begin
    best_prio = '0;
    best_id   = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (elig[s] && (best_id == '0 || prio_flat[s*PRIO_W +: PRIO_W] > best_prio)) begin
        best_prio = prio_flat[s*PRIO_W +: PRIO_W];
        best_id   = ID_W'(s + 1);
      end
    end
  end

  assign win_id = best_id;

  always_comb begin
    outranked = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (pend[s] && !ins[s] && src_en[s]
          && (tgt_flat[s*CORE_W +: CORE_W] == CORE_W'(CORE_IDX))
          && (prio_flat[s*PRIO_W +: PRIO_W] > thr)) begin
        if (win_id == '0) outranked = 1'b1;
        else if (int'(win_id) - 1 > s &&
                 prio_flat[s*PRIO_W +: PRIO_W] >= prio_flat[(int'(win_id)-1)*PRIO_W +: PRIO_W])
          outranked = 1'b1;
        else if (prio_flat[s*PRIO_W +: PRIO_W] > prio_flat[(int'(win_id)-1)*PRIO_W +: PRIO_W])
          outranked = 1'b1;
      end
    end
  end

  // R5
  winner_best_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !outranked);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_SRC  = 8,
  parameter int NUM_CORE = 2,
  parameter int PRIO_W   = 3,
  localparam int ID_W    = $clog2(NUM_SRC + 1),
  localparam int IDX_W   = $clog2(NUM_SRC),
  localparam int CORE_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       src_line,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_sel,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [PRIO_W-1:0]        cfg_wdata,
  output logic [NUM_CORE-1:0]      irq,
  input  logic [NUM_CORE-1:0]      claim_req,
  output logic [NUM_CORE*ID_W-1:0] claim_id,
  input  logic [NUM_CORE-1:0]      eoi_req,
  input  logic [NUM_CORE*ID_W-1:0] eoi_id
);

  logic                       rst_s1, rst_s2, rst_i;
  logic [NUM_SRC*PRIO_W-1:0]  prio_flat;
  logic [NUM_SRC-1:0]         src_en;
  logic [NUM_SRC*CORE_W-1:0]  tgt_flat;
  logic [NUM_CORE*PRIO_W-1:0] thr_flat;
  logic [NUM_SRC-1:0]         pend, ins, claim_hit, eoi_hit;
  logic [ID_W-1:0]            win_id [NUM_CORE];
  logic [NUM_CORE-1:0]        irq_d, irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign rst_i = rst_s2;

  pic_cfg_regs #(
    .NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .PRIO_W(PRIO_W),
    .CORE_W(CORE_W), .IDX_W(IDX_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_i), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .prio_flat(prio_flat),
    .src_en(src_en), .tgt_flat(tgt_flat), .thr_flat(thr_flat)
  );

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      claim_hit[s] = 1'b0;
      eoi_hit[s]   = 1'b0;
      for (int c = 0; c < NUM_CORE; c++) begin
        if (claim_req[c] && win_id[c] == ID_W'(s + 1)) claim_hit[s] = 1'b1;
        if (eoi_req[c] && eoi_id[c*ID_W +: ID_W] == ID_W'(s + 1)) eoi_hit[s] = 1'b1;
      end
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    pic_src_gate u_gate (
      .clk(clk), .rst_n(rst_i), .line(src_line[s]),
      .claim_hit(claim_hit[s]), .eoi_hit(eoi_hit[s]),
      .pend(pend[s]), .ins(ins[s])
    );
  end

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    pic_core_arb #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .CORE_W(CORE_W),
      .ID_W(ID_W), .CORE_IDX(c)
    ) u_arb (
      .clk(clk), .rst_n(rst_i), .pend(pend), .ins(ins), .src_en(src_en),
      .prio_flat(prio_flat), .tgt_flat(tgt_flat),
      .thr(thr_flat[c*PRIO_W +: PRIO_W]), .win_id(win_id[c])
    );
    assign claim_id[c*ID_W +: ID_W] = win_id[c];
    assign irq_d[c] = (win_id[c] != '0);

    if (c > 0) begin : g_excl
      // R4
      route_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_i)
        (win_id[c] != '0) |-> (win_id[c] != win_id[0]));
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC  = 8;
  localparam int NCORE = 2;
  localparam int PW    = 3;
  localparam int IW    = 4;
  localparam int XW    = 3;

  logic                clk;
  logic                rst_n;
  logic [NSRC-1:0]     src_line;
  logic                cfg_we;
  logic [1:0]          cfg_sel;
  logic [XW-1:0]       cfg_idx;
  logic [PW-1:0]       cfg_wdata;
  logic [NCORE-1:0]    irq;
  logic [NCORE-1:0]    claim_req;
  logic [NCORE*IW-1:0] claim_id;
  logic [NCORE-1:0]    eoi_req;
  logic [NCORE*IW-1:0] eoi_id;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    core;
    int    exp;
    string tag;
  } exp_item_t;
  exp_item_t exp_q[$];

  prio_irq_ctrl #(.NUM_SRC(NSRC), .NUM_CORE(NCORE), .PRIO_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_line(src_line), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .irq(irq),
    .claim_req(claim_req), .claim_id(claim_id), .eoi_req(eoi_req), .eoi_id(eoi_id)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg(input int sel, input int idx, input int val);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_idx = XW'(idx); cfg_wdata = PW'(val);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic setline(input int s, input logic v);
    @(posedge clk); #1;
    src_line[s] = v;
  endtask

  task automatic claim(input int core, input int exp, input string tag);
    exp_item_t it;
    @(posedge clk); #1;
    it.core = core; it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    claim_req[core] = 1'b1;
    @(posedge clk); #1;
    claim_req[core] = 1'b0;
  endtask

  task automatic eoi(input int core, input int id);
    @(posedge clk); #1;
    eoi_req[core] = 1'b1;
    eoi_id[core*IW +: IW] = IW'(id);
    @(posedge clk); #1;
    eoi_req[core] = 1'b0;
    eoi_id = '0;
  endtask

  task automatic chk_irq(input int core, input int exp, input string tag);
    @(negedge clk);
    chk(tag, int'(irq[core]), exp);
  endtask

  // monitor: pops the expected claim result for every strobe seen
  always @(negedge clk) begin
    for (int c = 0; c < NCORE; c++) begin
      if (claim_req[c] === 1'b1) begin
        if (exp_q.size() == 0) begin
          chk("claim without expectation", 1, 0);
        end else begin
          exp_item_t it;
          it = exp_q.pop_front();
          chk({it.tag, " core"}, c, it.core);
          chk(it.tag, int'(claim_id[c*IW +: IW]), it.exp);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_line = '0; cfg_we = 1'b0; cfg_sel = '0; cfg_idx = '0;
    cfg_wdata = '0; claim_req = '0; eoi_req = '0; eoi_id = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    @(negedge clk);
    chk("R1 irq", int'(irq), 0);
    chk("R1 claim_id", int'(claim_id), 0);

    // R1 thresholds, priorities and enables come up as 0: raise with nothing configured
    setline(0, 1'b1);
    tick(3);
    chk_irq(0, 0, "R1 nothing enabled");
    setline(0, 1'b0);

    // configuration: priorities, enables, targets
    cfg(0, 0, 3); cfg(0, 1, 5); cfg(0, 2, 5); cfg(0, 3, 0);
    cfg(0, 4, 2); cfg(0, 5, 4);
    for (int s = 0; s < 6; s++) cfg(1, s, 1);
    cfg(2, 5, 1);

    // R2 priority 0 never delivered
    setline(3, 1'b1);
    tick(3);
    chk_irq(0, 0, "R2 prio zero irq");
    claim(0, 0, "R2 prio zero claim");
    setline(3, 1'b0);

    // R5 ordering with tie
    @(posedge clk); #1;
    src_line[0] = 1'b1; src_line[1] = 1'b1; src_line[2] = 1'b1;
    tick(3);
    chk_irq(0, 1, "R5 irq raised");
    claim(0, 2, "R5 highest prio lowest id");
    claim(0, 3, "R5 tie second");
    claim(0, 1, "R5 lower prio last");
    claim(0, 0, "R6 all in service");

    // R6 new edge while in service is not delivered
    setline(1, 1'b0);
    tick(1);
    setline(1, 1'b1);
    tick(3);
    claim(0, 0, "R6 blocked during service");
    chk_irq(0, 0, "R6 irq low during service");

    // R7 eoi releases, held edge is delivered
    eoi(0, 2);
    tick(2);
    chk_irq(0, 1, "R7 irq after eoi");
    claim(0, 2, "R7 redelivered after eoi");
    eoi(0, 2); eoi(0, 3); eoi(0, 1);

    // R9 held lines without new edge are not redelivered
    tick(3);
    chk_irq(0, 0, "R9 irq stays low");
    claim(0, 0, "R9 level without edge");
    @(posedge clk); #1;
    src_line = '0;

    // R3 disable keeps pending, enable delivers
    cfg(1, 0, 0);
    setline(0, 1'b1);
    tick(3);
    chk_irq(0, 0, "R3 disabled irq");
    claim(0, 0, "R3 disabled claim");
    cfg(1, 0, 1);
    tick(2);
    chk_irq(0, 1, "R3 re-enabled irq");
    claim(0, 1, "R3 re-enabled claim");
    eoi(0, 1);
    setline(0, 1'b0);

    // R2 threshold equal blocks, lower passes
    cfg(3, 0, 3);
    setline(0, 1'b1);
    tick(3);
    chk_irq(0, 0, "R2 threshold equal");
    cfg(3, 0, 2);
    tick(2);
    chk_irq(0, 1, "R2 threshold below");
    claim(0, 1, "R2 claim above threshold");
    eoi(0, 1);
    setline(0, 1'b0);
    cfg(3, 0, 0);

    // R4 routing to core 1
    setline(5, 1'b1);
    tick(3);
    chk_irq(1, 1, "R4 target core irq");
    chk_irq(0, 0, "R4 other core irq");
    claim(0, 0, "R4 other core claim");
    claim(1, 6, "R4 target core claim");
    eoi(1, 6);
    setline(5, 1'b0);

    // R8 retracted line
    setline(4, 1'b1);
    tick(3);
    chk_irq(0, 1, "R8 irq before retract");
    setline(4, 1'b0);
    tick(2);
    claim(0, 0, "R8 spurious returns none");
    tick(1);
    chk_irq(0, 0, "R8 irq after retract");
    setline(4, 1'b1);
    tick(3);
    claim(0, 5, "R8 later edge still works");
    eoi(0, 5);
    setline(4, 1'b0);

    // R10 request output lags configuration by one clock
    setline(4, 1'b1);
    tick(3);
    chk_irq(0, 1, "R10 irq before disable");
    cfg(1, 4, 0);
    chk_irq(0, 1, "R10 irq one cycle after write");
    chk_irq(0, 0, "R10 irq two cycles after write");
    cfg(1, 4, 1);
    claim(0, 5, "R10 claim follows config same cycle");
    eoi(0, 5);
    setline(4, 1'b0);

    tick(4);
    chk("R6 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule